// File: doc/BRIEF.md
# Mode-Configurable DMA Channel Sequencer

This block sequences one DMA channel. Software picks a 3-bit transfer mode, programs a word count, a line length and two base addresses, and then writes the channel enable. The enable write also captures the count and the two bases. The channel then moves data one word at a time. Each word is a read from the source pointer followed by a write of that data to the destination pointer. Each leg uses a strobe that is held until the matching ready.

What starts a transfer depends on the mode. A peripheral request can move the whole block, a single word, or one line. One mode starts on the enable alone. At the end of a block the word counter and both pointers return to their programmed values. Depending on the mode, the block then either drops the enable or stays armed for the next request. It pulses a done output and, in the modes that allow it, an end-of-block interrupt. The bus fabric, arbitration between channels and the memory sit outside the block. The read and write handshakes stand in for them.

Top module: `dma_chan_seq`

## Requirements
- R1: While reset is asserted and right after it, `busy`, `de_o`, `done`, `eob_irq`, `rd_stb` and `wr_stb` are all low.
- R2: Each word is moved in two steps. First `rd_stb` is held with `rd_addr` until `rd_rdy`. Then `wr_stb` is held with `wr_addr` and the read data on `wr_data` until `wr_rdy`. Word k of a block reads `src_base+k` and writes `dst_base+k`, and the two strobes are never high together.
- R3: Modes 3'b000 and 3'b100 move the whole block on one `req`. Mode 3'b011 moves the whole block once the enable is set, with no `req`.
- R4: Modes 3'b001 and 3'b101 move exactly one word per `req`.
- R5: Mode 3'b010 moves `line_len` words per `req`. The final line is cut short where the block ends.
- R6: A block is `count_cfg` words, using the value captured when the enable was written to 1. After the block's final write handshake, `done` is high for exactly the next cycle, and the counter and both pointers return to their captured values.
- R7: At block end the enable drops in modes 3'b000 to 3'b011 and stays set in modes 3'b100 and 3'b101. A `req` while the enable is clear starts nothing.
- R8: `eob_irq` pulses together with `done` when `irq_en` is high and the mode is one of 3'b000 to 3'b011. It never asserts in modes 3'b100 or 3'b101.
- R9: In modes 3'b001 and 3'b101, one `req` that arrives while a word is in flight is held and served afterwards, and further ones are dropped. In the other request-driven modes, a `req` during a transfer is dropped.
- R10: Mode codes 3'b110 and 3'b111 never start a transfer, even with the enable set and `req` pulsed.
- R11: `busy` rises with the start of a transfer. It stays high without a gap until the write handshake of the last word of that request's burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Transfer mode code |
| de_wr | input | 1 | Write strobe for the channel enable |
| de_val | input | 1 | Enable value to write; writing 1 also captures count and bases |
| irq_en | input | 1 | End-of-block interrupt enable |
| count_cfg | input | CNT_W | Words per block (0 means 2^CNT_W) |
| line_len | input | CNT_W | Words per request in line mode |
| src_base | input | ADDR_W | First source address |
| dst_base | input | ADDR_W | First destination address |
| req | input | 1 | Peripheral request pulse |
| rd_stb | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read address |
| rd_rdy | input | 1 | Read accepted, data valid |
| rd_data | input | DATA_W | Read data |
| wr_stb | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data |
| wr_rdy | input | 1 | Write accepted |
| de_o | output | 1 | Current channel enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at block end |
| eob_irq | output | 1 | End-of-block interrupt pulse |

## Verification
The bench builds the block with a 4-bit count and line length and 8-bit addresses and data. This keeps every block short enough to sweep all eight mode codes against block lengths 1 to 5, both interrupt settings, and line lengths 1 to 3. The sweep therefore covers single-word blocks, lines that divide the block exactly, and a cut-short final line. The memory model stalls both handshakes on alternate cycles in half the runs. Focused runs push requests back to back into a busy channel, in word mode and in block mode, to exercise the one-deep pending request.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [2:0] {
    M_BLK_REQ    = 3'b000,
    M_WORD       = 3'b001,
    M_LINE       = 3'b010,
    M_BLK_SW     = 3'b011,
    M_BLK_REARM  = 3'b100,
    M_WORD_REARM = 3'b101,
    M_RSV_A      = 3'b110,
    M_RSV_B      = 3'b111
  } xfer_mode_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RD   = 2'd1,
    S_WR   = 2'd2
  } mv_state_e;

endpackage

// File: rtl/dma_seq_trig.sv
module dma_seq_trig
  import dma_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  input  logic             de_wr,
  input  logic             de_val,
  input  logic             irq_en,
  input  logic             req,
  input  logic             idle,
  input  logic             blk_end,
  input  logic [CNT_W-1:0] line_len,
  output logic             en_o,
  output logic             go,
  output logic             whole,
  output logic [CNT_W-1:0] burst_len,
  output logic             eob_irq
);

  xfer_mode_e md;
  logic       valid, need_req, rearm, word_mode, trig;
  logic       en_q, en_nxt, en_ce;
  logic       pend_q, pend_nxt;
  logic       irq_q, irq_nxt;

  assign md = xfer_mode_e'(mode);

  // mode decode
  always_comb begin
    valid     = 1'b1;
    need_req  = 1'b1;
    whole     = 1'b1;
    rearm     = 1'b0;
    word_mode = 1'b0;
    burst_len = CNT_W'(1);
    case (md)
      M_BLK_REQ:    ;
      M_WORD:       begin whole = 1'b0; word_mode = 1'b1; end
      M_LINE:       begin whole = 1'b0; burst_len = line_len; end
      M_BLK_SW:     need_req = 1'b0;
      M_BLK_REARM:  rearm = 1'b1;
      M_WORD_REARM: begin whole = 1'b0; word_mode = 1'b1; rearm = 1'b1; end
      default:      valid = 1'b0;
    endcase
  end

  assign trig = need_req ? (req | pend_q) : 1'b1;
  assign go   = idle & en_q & valid & trig;

  // next state
  always_comb begin
    en_ce  = (de_wr & idle) | (blk_end & ~rearm);
    en_nxt = blk_end ? 1'b0 : de_val;

    pend_nxt = pend_q;
    if (!idle && req && word_mode) pend_nxt = 1'b1;
    if (go && need_req)            pend_nxt = pend_q & req;
    if (blk_end && !rearm)         pend_nxt = 1'b0;
    if (de_wr && idle)             pend_nxt = 1'b0;

    irq_nxt = blk_end & irq_en & ~rearm;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (en_ce) en_q <= en_nxt;
      pend_q <= pend_nxt;
      irq_q  <= irq_nxt;
    end
  end

  assign en_o    = en_q;
  assign eob_irq = irq_q;

endmodule

// File: rtl/dma_seq_mover.sv
module dma_seq_mover
  import dma_seq_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ld,
  input  logic [CNT_W-1:0]  count_cfg,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic              go,
  input  logic              whole,
  input  logic [CNT_W-1:0]  burst_len,
  input  logic              rd_rdy,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              wr_rdy,
  output logic              idle,
  output logic              blk_end,
  output logic              done,
  output logic              rd_stb,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  mv_state_e         st_q, st_nxt;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt, shadow_q, bl_q, bl_nxt;
  logic [ADDR_W-1:0] sb_q, db_q, sp_q, dp_q, sp_nxt, dp_nxt;
  logic [DATA_W-1:0] data_q;
  logic              whole_q;
  logic              word_done, last_word, burst_last;
  logic              start, rd_take, cnt_ce, done_q;

  assign idle       = (st_q == S_IDLE);
  assign start      = idle & go;
  assign rd_take    = (st_q == S_RD) & rd_rdy;
  assign word_done  = (st_q == S_WR) & wr_rdy;
  assign last_word  = (cnt_q == CNT_ONE);
  assign blk_end    = word_done & last_word;
  assign burst_last = last_word | (~whole_q & (bl_q == CNT_ONE));
  assign cnt_ce     = cfg_ld | word_done;

  // next state
  always_comb begin
    st_nxt = st_q;
    case (st_q)
      S_IDLE:  if (go)     st_nxt = S_RD;
      S_RD:    if (rd_rdy) st_nxt = S_WR;
      S_WR:    if (wr_rdy) st_nxt = burst_last ? S_IDLE : S_RD;
      default: st_nxt = S_IDLE;
    endcase

    bl_nxt = start ? burst_len : (bl_q - CNT_ONE);

    if (cfg_ld) begin
      cnt_nxt = count_cfg;
      sp_nxt  = src_base;
      dp_nxt  = dst_base;
    end else if (last_word) begin
      cnt_nxt = shadow_q;
      sp_nxt  = sb_q;
      dp_nxt  = db_q;
    end else begin
      cnt_nxt = cnt_q - CNT_ONE;
      sp_nxt  = sp_q + ADDR_ONE;
      dp_nxt  = dp_q + ADDR_ONE;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      cnt_q    <= '0;
      shadow_q <= '0;
      bl_q     <= '0;
      whole_q  <= 1'b0;
      sb_q     <= '0;
      db_q     <= '0;
      sp_q     <= '0;
      dp_q     <= '0;
      data_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      st_q   <= st_nxt;
      done_q <= blk_end;
      if (start | word_done) bl_q <= bl_nxt;
      if (start) whole_q <= whole;
      if (rd_take) data_q <= rd_data;
      if (cfg_ld) begin
        shadow_q <= count_cfg;
        sb_q     <= src_base;
        db_q     <= dst_base;
      end
      if (cnt_ce) begin
        cnt_q <= cnt_nxt;
        sp_q  <= sp_nxt;
        dp_q  <= dp_nxt;
      end
    end
  end

  assign done    = done_q;
  assign rd_stb  = (st_q == S_RD);
  assign rd_addr = sp_q;
  assign wr_stb  = (st_q == S_WR);
  assign wr_addr = dp_q;
  assign wr_data = data_q;

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic              de_wr,
  input  logic              de_val,
  input  logic              irq_en,
  input  logic [CNT_W-1:0]  count_cfg,
  input  logic [CNT_W-1:0]  line_len,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic              req,
  output logic              rd_stb,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_rdy,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_rdy,
  output logic              de_o,
  output logic              busy,
  output logic              done,
  output logic              eob_irq
);

  logic             idle, blk_end, go, whole;
  logic [CNT_W-1:0] burst_len;
  logic             cfg_ld;

  assign cfg_ld = de_wr & de_val & idle;
  assign busy   = ~idle;

  dma_seq_trig #(.CNT_W(CNT_W)) u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .de_wr     (de_wr),
    .de_val    (de_val),
    .irq_en    (irq_en),
    .req       (req),
    .idle      (idle),
    .blk_end   (blk_end),
    .line_len  (line_len),
    .en_o      (de_o),
    .go        (go),
    .whole     (whole),
    .burst_len (burst_len),
    .eob_irq   (eob_irq)
  );

  dma_seq_mover #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mover (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_ld    (cfg_ld),
    .count_cfg (count_cfg),
    .src_base  (src_base),
    .dst_base  (dst_base),
    .go        (go),
    .whole     (whole),
    .burst_len (burst_len),
    .rd_rdy    (rd_rdy),
    .rd_data   (rd_data),
    .wr_rdy    (wr_rdy),
    .idle      (idle),
    .blk_end   (blk_end),
    .done      (done),
    .rd_stb    (rd_stb),
    .rd_addr   (rd_addr),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode,
  input logic              rd_stb,
  input logic              rd_rdy,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_stb,
  input logic              wr_rdy,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              busy,
  input logic              done,
  input logic              eob_irq,
  input logic              de_o
);

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rd_stb && wr_stb)); // R2
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) rd_stb && !rd_rdy |=> rd_stb && $stable(rd_addr)); // R2
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) wr_stb && !wr_rdy |=> wr_stb && $stable(wr_addr) && $stable(wr_data)); // R2
  AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $past(wr_stb && wr_rdy)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
  AST_DE_KEPT: assert property (@(posedge clk) disable iff (!rst_n) done && mode[2] |-> de_o); // R7
  AST_DE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n) done && !mode[2] |-> !de_o); // R7
  AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) eob_irq |-> done); // R8
  AST_NO_IRQ_REARM: assert property (@(posedge clk) disable iff (!rst_n) eob_irq |-> !mode[2]); // R8
  AST_RSV_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (mode[2:1] == 2'b11) && !busy |=> !busy); // R10
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(wr_stb && wr_rdy)); // R11

endmodule

bind dma_chan_seq dma_chan_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mode    (mode),
  .rd_stb  (rd_stb),
  .rd_rdy  (rd_rdy),
  .rd_addr (rd_addr),
  .wr_stb  (wr_stb),
  .wr_rdy  (wr_rdy),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .busy    (busy),
  .done    (done),
  .eob_irq (eob_irq),
  .de_o    (de_o)
);

// File: tb/dma_chan_seq_tb.sv
module dma_chan_seq_tb;

  localparam int CW = 4;
  localparam int AW = 8;
  localparam int DW = 8;

  logic          clk;
  logic          rst_n;
  logic [2:0]    mode;
  logic          de_wr, de_val, irq_en, req;
  logic [CW-1:0] count_cfg, line_len;
  logic [AW-1:0] src_base, dst_base, rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;
  logic          rd_stb, rd_rdy, wr_stb, wr_rdy;
  logic          de_o, busy, done, eob_irq;

  int  total, bad;
  int  sb, db, ecnt, widx, n_wr, n_done, n_irq;
  bit  saw_busy, slow, tgl, finished;

  dma_chan_seq #(.CNT_W(CW), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .de_wr(de_wr), .de_val(de_val),
    .irq_en(irq_en), .count_cfg(count_cfg), .line_len(line_len),
    .src_base(src_base), .dst_base(dst_base), .req(req),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_rdy(rd_rdy), .rd_data(rd_data),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .wr_rdy(wr_rdy),
    .de_o(de_o), .busy(busy), .done(done), .eob_irq(eob_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // memory model: ready on the negedge after a strobe, optionally every other cycle
  always @(negedge clk) begin
    tgl     = ~tgl;
    rd_rdy  = rd_stb && !(slow && tgl);
    wr_rdy  = wr_stb && !(slow && tgl);
    rd_data = rd_addr ^ 8'hA5;
  end

  // write monitor
  always @(posedge clk) begin
    if (rst_n) begin
      if (busy) saw_busy = 1'b1;
      if (wr_stb && wr_rdy) begin
        chk(int'(wr_addr) == ((db + widx) & 255), "R2 wr_addr", int'(wr_addr), (db + widx) & 255);
        chk(int'(wr_data) == (((sb + widx) & 255) ^ 'hA5), "R2 wr_data",
            int'(wr_data), ((sb + widx) & 255) ^ 'hA5);
        n_wr++;
        widx++;
        if (widx == ecnt) widx = 0;
      end
      if (done) n_done++;
      if (eob_irq) n_irq++;
    end
  end

  task automatic pulse_req();
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic setup(input int m, input int c, input int ie, input int ln);
    @(negedge clk); de_wr = 1'b1; de_val = 1'b0;
    @(negedge clk); de_wr = 1'b0;
    mode      = 3'(m);
    count_cfg = CW'(c);
    line_len  = CW'(ln);
    irq_en    = ie[0];
    slow      = ie[0];
    sb        = (16 * m + c) & 255;
    db        = (200 + 3 * c) & 255;
    src_base  = AW'(sb);
    dst_base  = AW'(db);
    ecnt = c; widx = 0; n_wr = 0; n_done = 0; n_irq = 0; saw_busy = 1'b0;
    @(negedge clk); de_wr = 1'b1; de_val = 1'b1;
    @(negedge clk); de_wr = 1'b0;
  endtask

  task automatic run_case(input int m, input int c, input int ie, input int ln);
    int ereq, nreq, blocks;
    setup(m, c, ie, ln);
    blocks = (m >= 4) ? 2 : 1;
    if (m >= 6) begin
      repeat (6) @(negedge clk);
      pulse_req();
      repeat (6) @(negedge clk);
      chk(n_wr == 0, "R10 reserved mode words", n_wr, 0);
      chk(!saw_busy, "R10 reserved mode busy", int'(saw_busy), 0);
    end else begin
      if (m == 3) begin
        for (int i = 0; i < 200 && n_done == 0; i++) @(negedge clk);
        chk(n_wr == c, "R3 enable-started block words", n_wr, c);
      end else begin
        ereq = (m == 2) ? (c + ln - 1) / ln : ((m == 1 || m == 5) ? c : 1);
        for (int b = 0; b < blocks; b++) begin
          nreq = 0;
          while (n_done == b && nreq < 40) begin
            pulse_req();
            wait_idle();
            nreq++;
            if ((m == 0 || m == 4) && nreq == 1)
              chk(n_wr == c * (b + 1), "R11 busy held over whole block", n_wr, c * (b + 1));
          end
          if (m == 2)      chk(nreq == ereq, "R5 requests per block", nreq, ereq);
          else if (m == 1 || m == 5) chk(nreq == ereq, "R4 requests per block", nreq, ereq);
          else             chk(nreq == ereq, "R3 requests per block", nreq, ereq);
          chk(n_wr == c * (b + 1), "R6 words after block", n_wr, c * (b + 1));
        end
      end
      chk(n_done == blocks, "R6 done pulses", n_done, blocks);
      chk(n_irq == ((ie == 1 && m < 4) ? 1 : 0), "R8 interrupt count", n_irq,
          (ie == 1 && m < 4) ? 1 : 0);
      chk(de_o == (m >= 4), "R7 enable after block", int'(de_o), (m >= 4) ? 1 : 0);
      if (m < 4) begin
        pulse_req();
        repeat (8) @(negedge clk);
        chk(n_wr == c, "R7 request ignored with enable clear", n_wr, c);
      end
    end
  endtask

  initial begin
    total = 0; bad = 0; finished = 1'b0; tgl = 1'b0; slow = 1'b0;
    ecnt = 1; widx = 0; n_wr = 0; n_done = 0; n_irq = 0; sb = 0; db = 0;
    rst_n = 1'b0; mode = 3'b000; de_wr = 1'b0; de_val = 1'b0; irq_en = 1'b0; req = 1'b0;
    count_cfg = '0; line_len = '0; src_base = '0; dst_base = '0;
    rd_rdy = 1'b0; wr_rdy = 1'b0; rd_data = '0;
    repeat (3) @(negedge clk);
    chk(!busy, "R1 busy in reset", int'(busy), 0);
    chk(!de_o, "R1 enable in reset", int'(de_o), 0);
    chk(!done && !eob_irq, "R1 done/irq in reset", int'(done) + int'(eob_irq), 0);
    chk(!rd_stb && !wr_stb, "R1 strobes in reset", int'(rd_stb) + int'(wr_stb), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !de_o, "R1 idle after reset", int'(busy) + int'(de_o), 0);

    for (int m = 0; m < 8; m++)
      for (int c = 1; c <= 5; c++)
        for (int ie = 0; ie < 2; ie++)
          for (int ln = 1; ln <= ((m == 2) ? 3 : 1); ln++)
            run_case(m, c, ie, ln);

    // R9: word mode holds one request that arrives while busy, drops the third
    setup(5, 5, 0, 1);
    @(negedge clk); req = 1'b1;
    repeat (3) @(negedge clk);
    req = 1'b0;
    repeat (20) @(negedge clk);
    chk(n_wr == 2, "R9 pending request served once", n_wr, 2);

    // R9: block mode drops requests during a transfer
    setup(0, 4, 0, 1);
    @(negedge clk); req = 1'b1;
    repeat (3) @(negedge clk);
    req = 1'b0;
    repeat (30) @(negedge clk);
    chk(n_wr == 4 && n_done == 1, "R9 block mode no queued request", n_wr, 4);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule